// File: doc/BRIEF.md
# Dual-Mode Capture/Compare Register Bank

This block holds a small bank of 16-bit timer registers that all observe one shared free-running count value. At run time, software sets each register to one of two jobs. In capture duty, the register records the count when a chosen transition appears on its own external input. In compare duty, the register checks its value against the count on every cycle. On equality it updates a compare output and can fire a start strobe toward a linked down-counter.

Each register has its own status flag. A capture or a match sets the flag, and software clears it. The CPU reaches the registers, their control words and the status word over a plain word-wide register port. Accesses narrower than a word are rejected. The count and the down-counter are outside the block: the count is an input, and the start strobe is only an output.

Top module: `capcmp_bank`

## Requirements
- R1: After reset every timer register reads 0xFFFF, every control word and the status word read 0, and all compare outputs and start strobes are low.
- R2: Control bit 0 picks the duty: 0 = capture, 1 = compare. A register in compare duty ignores its capture input, and a register in capture duty never reports a match.
- R3: In capture duty the capture input passes through two synchronizer flops, and on the selected transition the register loads the count. Control bits [2:1] select the transition: 00 = none, 01 = rising, 10 = falling, 11 = either.
- R4: A capture sets that register's status flag.
- R5: In compare duty, equality of the register and the count sets the register's status flag on the next clock edge.
- R6: Control bits [4:3] choose what a match does to that register's compare output on the next edge: 00 = keep, 01 = low, 10 = high, 11 = invert.
- R7: When control bit 5 is 1, a match raises that register's start strobe for the next cycle only. When bit 5 is 0, the strobe stays low.
- R8: Only word accesses (bus_word = 1) are honoured. A write with bus_word = 0 changes nothing, and a read with bus_word = 0 returns 0.
- R9: The status word sits at address 2N, with bit i holding register i's flag. Writing 0 to a bit clears it and writing 1 has no effect. A capture or match in the same cycle as a clear leaves the flag set.
- R10: Register i sits at address i and its control word sits at address N+i. Reads of any other address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cnt_val | input | W | Shared free-running count |
| cap_in | input | N | External capture inputs, one per register |
| cmp_out | output | N | Compare outputs, one per register |
| dcnt_start | output | N | One-cycle start strobes to linked down-counters |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_word | input | 1 | 1 = full word access, 0 = byte access |
| bus_addr | input | clog2(2N+1) | Register address |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Read data, valid in the access cycle |

## Verification
A compare match and a CPU clear of the same status flag can land in the same cycle, and the flag must stay set. The bench provokes this by driving the count to a compare register's value in the same cycle as a status write of 0. It then moves the count away and reads the status word back through the bus, expecting the bit to still be 1. A clear with no competing event is also checked, to show that the clear path itself works.

// File: rtl/capcmp_bank.sv
`timescale 1ns/1ps
module capcmp_bank #(
  parameter int N = 4,
  parameter int W = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [W-1:0]                  cnt_val,
  input  logic [N-1:0]                  cap_in,
  output logic [N-1:0]                  cmp_out,
  output logic [N-1:0]                  dcnt_start,
  input  logic                          bus_sel,
  input  logic                          bus_wr,
  input  logic                          bus_word,
  input  logic [$clog2(2*N+1)-1:0]      bus_addr,
  input  logic [W-1:0]                  bus_wdata,
  output logic [W-1:0]                  bus_rdata
);
  localparam int AW   = $clog2(2*N+1);
  localparam int CW   = 6;
  localparam int STAT = 2*N;

  logic [N-1:0][W-1:0]  gr_q;
  logic [N-1:0][CW-1:0] ctrl_q;
  logic [N-1:0]         flag_q;
  logic [N-1:0]         sync1, sync2, sync3;

  wire word_wr = bus_sel & bus_wr & bus_word;
  wire stat_wr = word_wr & (bus_addr == AW'(STAT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      sync3 <= '0;
    end else begin
      sync1 <= cap_in;
      sync2 <= sync1;
      sync3 <= sync2;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_reg
    logic [W-1:0]  gr_r;
    logic [CW-1:0] ctrl_r;
    logic          flag_r, out_r, start_r;

    wire       cmp_mode = ctrl_r[0];
    wire [1:0] edge_sel = ctrl_r[2:1];
    wire [1:0] act      = ctrl_r[4:3];
    wire       link     = ctrl_r[5];
    wire       rise     = sync2[i] & ~sync3[i];
    wire       fall     = ~sync2[i] & sync3[i];
    wire       cap      = ~cmp_mode & ((edge_sel[0] & rise) | (edge_sel[1] & fall));
    wire       hit      = cmp_mode & (gr_r == cnt_val);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        gr_r    <= '1;
        ctrl_r  <= '0;
        flag_r  <= 1'b0;
        out_r   <= 1'b0;
        start_r <= 1'b0;
      end else begin
        if (cap)
          gr_r <= cnt_val;
        else if (word_wr && bus_addr == AW'(i))
          gr_r <= bus_wdata;

        if (word_wr && bus_addr == AW'(N + i))
          ctrl_r <= bus_wdata[CW-1:0];

        if (cap || hit)
          flag_r <= 1'b1;
        else if (stat_wr && !bus_wdata[i])
          flag_r <= 1'b0;

        if (hit) begin
          case (act)
            2'b01:   out_r <= 1'b0;
            2'b10:   out_r <= 1'b1;
            2'b11:   out_r <= ~out_r;
            default: out_r <= out_r;
          endcase
        end

        start_r <= hit & link;
      end
    end

    assign gr_q[i]       = gr_r;
    assign ctrl_q[i]     = ctrl_r;
    assign flag_q[i]     = flag_r;
    assign cmp_out[i]    = out_r;
    assign dcnt_start[i] = start_r;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr && bus_word) begin
      for (int k = 0; k < N; k++) begin
        if (bus_addr == AW'(k))     bus_rdata = gr_q[k];
        if (bus_addr == AW'(N + k)) bus_rdata = {{(W-CW){1'b0}}, ctrl_q[k]};
      end
      if (bus_addr == AW'(STAT)) bus_rdata = {{(W-N){1'b0}}, flag_q};
    end
  end
endmodule

// File: rtl/capcmp_bank_chk.sv
`timescale 1ns/1ps
module capcmp_bank_chk #(
  parameter int N = 4,
  parameter int W = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [W-1:0]             cnt_val,
  input logic [N-1:0]             cmp_out,
  input logic [N-1:0]             dcnt_start,
  input logic                     bus_sel,
  input logic                     bus_wr,
  input logic                     bus_word,
  input logic [$clog2(2*N+1)-1:0] bus_addr,
  input logic [W-1:0]             bus_wdata,
  input logic [W-1:0]             bus_rdata,
  input logic [N-1:0][W-1:0]      gr_q,
  input logic [N-1:0][5:0]        ctrl_q,
  input logic [N-1:0]             flag_q
);
  localparam int AW = $clog2(2*N+1);

  AST_BYTE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && !bus_word) |-> bus_rdata == '0); // R8

  for (genvar i = 0; i < N; i++) begin : g_chk
    AST_FLAG_DROP_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_q[i]) |-> $past(bus_sel && bus_wr && bus_word &&
                                 bus_addr == AW'(2*N) && !bus_wdata[i])); // R9

    AST_START_NEEDS_LINKED_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      dcnt_start[i] |-> $past(ctrl_q[i][0] && ctrl_q[i][5] && gr_q[i] == cnt_val)); // R7

    AST_START_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      dcnt_start[i] |-> flag_q[i]); // R5

    AST_TOGGLE_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ctrl_q[i][0] && ctrl_q[i][4:3] == 2'b11 && gr_q[i] == cnt_val)
        |-> cmp_out[i] != $past(cmp_out[i])); // R6
  end
endmodule

bind capcmp_bank capcmp_bank_chk #(.N(N), .W(W)) u_chk (.*);

// File: tb/test_capcmp_bank.sv
`timescale 1ns/1ps
module test_capcmp_bank;
  localparam int N  = 4;
  localparam int W  = 16;
  localparam int AW = $clog2(2*N+1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [W-1:0]  cnt_val = '0;
  logic [N-1:0]  cap_in = '0;
  logic [N-1:0]  cmp_out, dcnt_start;
  logic          bus_sel = 1'b0, bus_wr = 1'b0, bus_word = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic [W-1:0]  bus_wdata = '0;
  logic [W-1:0]  bus_rdata;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [W-1:0] exp_q[$];
  string        tag_q[$];
  logic [W-1:0] m_exp;
  string        m_tag;

  always #2 clk = ~clk;

  capcmp_bank #(.N(N), .W(W)) i_capcmp_bank (.*);

  task automatic chk(input logic [W-1:0] act, input logic [W-1:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input int a, input logic [W-1:0] d, input bit word = 1'b1);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_word = word;
    bus_addr = AW'(a); bus_wdata = d;
    tick();
    bus_sel = 1'b0; bus_wr = 1'b0; bus_word = 1'b1;
  endtask

  task automatic rd(input int a, input logic [W-1:0] exp, input string tag, input bit word = 1'b1);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_word = word; bus_addr = AW'(a);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    tick();
    bus_sel = 1'b0; bus_word = 1'b1;
  endtask

  always @(negedge clk) begin
    if (bus_sel && !bus_wr && exp_q.size() > 0) begin
      m_exp = exp_q.pop_front();
      m_tag = tag_q.pop_front();
      chk(bus_rdata, m_exp, m_tag);
    end
  end

  initial begin
    #800000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    for (int k = 0; k < N; k++) rd(k, 16'hFFFF, "R1 reg reset");
    rd(2*N, 16'h0000, "R1 status reset");
    rd(N, 16'h0000, "R1 ctrl reset");
    chk(W'(cmp_out), 16'h0, "R1 cmp_out reset");
    chk(W'(dcnt_start), 16'h0, "R1 start reset");
    rd(2*N + 1, 16'h0000, "R10 unmapped read");

    wr(0, 16'h1234);
    rd(0, 16'h1234, "R10 word write");
    wr(0, 16'hAAAA, 1'b0);
    rd(0, 16'h1234, "R8 byte write ignored");
    rd(0, 16'h0000, "R8 byte read zero", 1'b0);

    wr(N + 0, 16'h0031);
    rd(N + 0, 16'h0031, "R10 ctrl readback");
    cnt_val = 16'h1234; tick();
    chk(W'(cmp_out[0]), 16'h1, "R6 drive high");
    chk(W'(dcnt_start[0]), 16'h1, "R7 start pulse");
    cnt_val = 16'h1235; tick();
    chk(W'(dcnt_start[0]), 16'h0, "R7 start one cycle");
    chk(W'(cmp_out[0]), 16'h1, "R6 output held");
    rd(2*N, 16'h0001, "R5 match flag");

    wr(1, 16'h0050);
    wr(N + 1, 16'h0019);
    cnt_val = 16'h0050; tick();
    chk(W'(cmp_out[1]), 16'h1, "R6 toggle up");
    chk(W'(dcnt_start[1]), 16'h0, "R7 no link no start");
    cnt_val = 16'h0051; tick();
    cnt_val = 16'h0050; tick();
    chk(W'(cmp_out[1]), 16'h0, "R6 toggle down");
    cnt_val = 16'h0051;

    wr(N + 0, 16'h0009);
    cnt_val = 16'h1234; tick();
    cnt_val = 16'h0000;
    chk(W'(cmp_out[0]), 16'h0, "R6 drive low");
    rd(2*N, 16'h0003, "R5 two flags");

    wr(2*N, 16'hFFFF);
    rd(2*N, 16'h0003, "R9 write one no effect");
    wr(2*N, 16'hFFFE);
    rd(2*N, 16'h0002, "R9 clear bit0");
    wr(2*N, 16'h0000);
    rd(2*N, 16'h0000, "R9 clear all");

    wr(N + 2, 16'h0002);
    cnt_val = 16'hFFFF; tick(); tick();
    rd(2*N, 16'h0000, "R2 capture duty no match");

    cnt_val = 16'h0777; cap_in[2] = 1'b1;
    repeat (4) tick();
    rd(2, 16'h0777, "R3 rising capture");
    rd(2*N, 16'h0004, "R4 capture flag");
    cnt_val = 16'h0888; cap_in[2] = 1'b0;
    repeat (4) tick();
    rd(2, 16'h0777, "R3 falling ignored in rising mode");

    wr(N + 3, 16'h0004);
    cnt_val = 16'h0999; cap_in[3] = 1'b1;
    repeat (4) tick();
    rd(3, 16'hFFFF, "R3 rising ignored in falling mode");
    cap_in[3] = 1'b0;
    repeat (4) tick();
    rd(3, 16'h0999, "R3 falling capture");

    wr(N + 2, 16'h0006);
    cnt_val = 16'h0AAA; cap_in[2] = 1'b1;
    repeat (4) tick();
    rd(2, 16'h0AAA, "R3 both edges rise");
    cnt_val = 16'h0BBB; cap_in[2] = 1'b0;
    repeat (4) tick();
    rd(2, 16'h0BBB, "R3 both edges fall");

    wr(N + 2, 16'h0000);
    cnt_val = 16'h0CCC; cap_in[2] = 1'b1;
    repeat (4) tick();
    rd(2, 16'h0BBB, "R3 capture disabled");

    cnt_val = 16'h0DDD; cap_in[0] = 1'b1;
    repeat (4) tick();
    rd(0, 16'h1234, "R2 compare duty ignores capture");
    cap_in[0] = 1'b0;
    repeat (4) tick();

    wr(2*N, 16'h0000);
    rd(2*N, 16'h0000, "R9 clear before collision");
    cnt_val = 16'h1234;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_word = 1'b1;
    bus_addr = AW'(2*N); bus_wdata = 16'h0000;
    tick();
    bus_sel = 1'b0; bus_wr = 1'b0;
    cnt_val = 16'h0000;
    rd(2*N, 16'h0001, "R9 match beats clear");

    repeat (2) tick();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule